// File: doc/BRIEF.md
# Split Compressor-Tree Multiplier

An unsigned N×N multiplier built from a partial-product array, a reduction tree of 4:2 compressors and a parallel prefix final adder. The default size is 16×16, and 32×32 is a parameter setting. The multiplier rows are shared between two identical half-trees. The low half-tree takes the rows for the low half of the multiplier bits. The high half-tree takes the rows for the upper half of the multiplier bits. Each half-tree reduces its rows to two terms. A root stage holds one last compressor row and the prefix adder.

A mode input selects between two uses. In full mode, the root shifts the high half-tree's two terms up by N/2 places, compresses all four terms to two and adds them into the 2N-bit product. In split mode, each half-tree drives its own final adder. The unit then returns two independent products, A times the low multiplier half and A times the high multiplier half. Each is N+N/2 bits wide and neither is shifted. The block is purely combinational and has no state.

Top module: `mt_mul_split`

## Requirements
- R1: With split_en low, prod_full equals the unsigned product a_op × b_op over 2N bits.
- R2: Every 4:2 compressor row keeps the arithmetic sum: sum plus carry vector, plus the bits that leave the top column, equals the sum of its four input rows.
- R3: The prefix final adder returns the 2N-bit sum of its two input rows, modulo 2^(2N).
- R4: With split_en high, prod_lo equals a_op × b_op[N/2-1:0], and no bit above position N+N/2-1 is set in its adder result.
- R5: With split_en high, prod_hi equals a_op × b_op[N-1:N/2], not shifted by N/2.
- R6: With split_en low, prod_lo and prod_hi are zero. With split_en high, prod_full is zero.
- R7: Corner operands give exact results in both modes: a zero operand gives zero, an operand of one gives the other operand, and all-ones × all-ones gives (2^N-1)^2.
- R8: In split mode, prod_lo + (prod_hi << N/2) equals the full product a_op × b_op.
- R9: The outputs follow a change of split_en or of the operands with no clock edge, since the block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | N | Multiplicand, unsigned |
| b_op | input | N | Multiplier, unsigned; its low and high halves feed the two half-trees |
| split_en | input | 1 | 0: one N×N product; 1: two N×(N/2) products |
| prod_full | output | 2N | Full product in full mode, zero in split mode |
| prod_lo | output | N+N/2 | a_op × low multiplier half in split mode, zero otherwise |
| prod_hi | output | N+N/2 | a_op × high multiplier half in split mode, zero otherwise |

## Verification
The bench targets all-ones operands. If a compressor dropped a carry that leaves a column, or the prefix network combined propagate terms wrongly, these operands would give a product that is off in the high bits. It also tests multipliers with only one half non-zero. A root that failed to shift the high half-tree by N/2 would then return a value off by a power of two in full mode. An unshifted high result that was wrongly realigned would show up in split mode. Switching split_en back and forth on the same operands exposes a mode gate that leaks one result onto another port, and recombining the two halves catches a half-tree that was fed the wrong multiplier bits.

// File: rtl/mt_pkg.sv
`timescale 1ns/1ps
package mt_pkg;
  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_SPLIT = 1'b1
  } mt_mode_e;

  // number of 4:2 levels needed to bring r rows down to two
  function automatic int tree_levels(input int r);
    int n;
    int lv;
    n  = r;
    lv = 0;
    while (n > 2) begin
      n  = n / 2;
      lv = lv + 1;
    end
    return lv;
  endfunction
endpackage

// File: rtl/mt_comp42_row.sv
`timescale 1ns/1ps
module mt_comp42_row #(
  parameter int W = 32
) (
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  input  logic [W-1:0] in2,
  input  logic [W-1:0] in3,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cy_o
);
  // named internal events for the checks below
  logic [W-1:0] x3;      // first full-adder sum per column
  logic [W-1:0] cout_w;  // carry-out, independent of carry-in
  logic [W-1:0] cin_w;   // carry-in taken from the column below
  logic [W-1:0] cy_raw;  // second full-adder carry, unshifted

  always_comb begin
    x3     = in0 ^ in1 ^ in2;
    cout_w = (in0 & in1) | (in0 & in2) | (in1 & in2);
    cin_w  = {cout_w[W-2:0], 1'b0};
    sum_o  = x3 ^ in3 ^ cin_w;
    cy_raw = (x3 & in3) | (x3 & cin_w) | (in3 & cin_w);
    cy_o   = {cy_raw[W-2:0], 1'b0};
  end

  logic [W+1:0] lhs_w, rhs_w;
  always_comb begin
    lhs_w = (W+2)'(sum_o) + (W+2)'(cy_o)
          + ((W+2)'(cout_w[W-1]) << W) + ((W+2)'(cy_raw[W-1]) << W);
    rhs_w = (W+2)'(in0) + (W+2)'(in1) + (W+2)'(in2) + (W+2)'(in3);
    // R2: compression preserves the exact sum of the four rows
    a_r2_sum_kept: assert (lhs_w == rhs_w)
      else $error("compressor sum mismatch");
  end
endmodule

// File: rtl/mt_prefix_add.sv
`timescale 1ns/1ps
module mt_prefix_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);
  localparam int L = $clog2(W);

  logic [W-1:0] gen_w;   // group generate, after all levels
  logic [W-1:0] prop_w;  // group propagate, after all levels
  logic [W-1:0] carry_w; // carry into each bit

  always_comb begin
    gen_w  = x_i & y_i;
    prop_w = x_i ^ y_i;
    for (int k = 0; k < L; k++) begin
      gen_w  = gen_w | (prop_w & (gen_w << (1 << k)));
      prop_w = prop_w & ((prop_w << (1 << k)) | ((W'(1) << (1 << k)) - W'(1)));
    end
    carry_w = {gen_w[W-2:0], 1'b0};
    sum_o   = x_i ^ y_i ^ carry_w;
  end

  always_comb begin
    // R3: prefix network yields the modular sum of its inputs
    a_r3_prefix_sum: assert (sum_o == W'(x_i + y_i))
      else $error("prefix adder mismatch");
  end
endmodule

// File: rtl/mt_half_tree.sv
`timescale 1ns/1ps
module mt_half_tree #(
  parameter int N = 16,
  parameter int W = 2 * N
) (
  input  logic [N-1:0]   mcand_i,
  input  logic [N/2-1:0] mbits_i,
  output logic [W-1:0]   term0_o,
  output logic [W-1:0]   term1_o
);
  localparam int R  = N / 2;
  localparam int LV = mt_pkg::tree_levels(R);

  for (genvar k = 0; k <= LV; k++) begin : g_lv
    localparam int ROWS = R >> k;
    logic [ROWS*W-1:0] v;
    if (k == 0) begin : g_pp
      for (genvar j = 0; j < R; j++) begin : g_row
        assign v[j*W +: W] = mbits_i[j] ? (W'(mcand_i) << j) : '0;
      end
    end else begin : g_red
      for (genvar g = 0; g < ROWS / 2; g++) begin : g_cmp
        mt_comp42_row #(.W(W)) u_cmp (
          .in0  (g_lv[k-1].v[(4*g+0)*W +: W]),
          .in1  (g_lv[k-1].v[(4*g+1)*W +: W]),
          .in2  (g_lv[k-1].v[(4*g+2)*W +: W]),
          .in3  (g_lv[k-1].v[(4*g+3)*W +: W]),
          .sum_o(v[(2*g+0)*W +: W]),
          .cy_o (v[(2*g+1)*W +: W])
        );
      end
    end
  end

  assign term0_o = g_lv[LV].v[0 +: W];
  assign term1_o = g_lv[LV].v[W +: W];
endmodule

// File: rtl/mt_mul_split.sv
`timescale 1ns/1ps
module mt_mul_split #(
  parameter int N = 16
) (
  input  logic [N-1:0]       a_op,
  input  logic [N-1:0]       b_op,
  input  logic               split_en,
  output logic [2*N-1:0]     prod_full,
  output logic [N+N/2-1:0]   prod_lo,
  output logic [N+N/2-1:0]   prod_hi
);
  localparam int W  = 2 * N;
  localparam int H  = N / 2;
  localparam int HW = N + H;

  mt_pkg::mt_mode_e mode_w;
  assign mode_w = mt_pkg::mt_mode_e'(split_en);

  logic [W-1:0] lo_t0, lo_t1, hi_t0, hi_t1;

  mt_half_tree #(.N(N), .W(W)) u_tree_lo (
    .mcand_i(a_op), .mbits_i(b_op[H-1:0]), .term0_o(lo_t0), .term1_o(lo_t1)
  );
  mt_half_tree #(.N(N), .W(W)) u_tree_hi (
    .mcand_i(a_op), .mbits_i(b_op[N-1:H]), .term0_o(hi_t0), .term1_o(hi_t1)
  );

  // root: align the high half-tree and compress four terms to two
  logic [W-1:0] root_s, root_c;
  mt_comp42_row #(.W(W)) u_root (
    .in0(lo_t0), .in1(lo_t1), .in2(hi_t0 << H), .in3(hi_t1 << H),
    .sum_o(root_s), .cy_o(root_c)
  );

  // final adder 0 serves the root in full mode, the low tree in split mode
  logic [W-1:0] fa0_x, fa0_y, fa0_sum, fa1_sum;
  assign fa0_x = (mode_w == mt_pkg::MODE_SPLIT) ? lo_t0 : root_s;
  assign fa0_y = (mode_w == mt_pkg::MODE_SPLIT) ? lo_t1 : root_c;

  mt_prefix_add #(.W(W)) u_fadd0 (.x_i(fa0_x), .y_i(fa0_y), .sum_o(fa0_sum));
  mt_prefix_add #(.W(W)) u_fadd1 (.x_i(hi_t0), .y_i(hi_t1), .sum_o(fa1_sum));

  always_comb begin
    prod_full = '0;
    prod_lo   = '0;
    prod_hi   = '0;
    if (mode_w == mt_pkg::MODE_SPLIT) begin
      prod_lo = fa0_sum[HW-1:0];
      prod_hi = fa1_sum[HW-1:0];
    end else begin
      prod_full = fa0_sum;
    end
  end

  always_comb begin
    // R1: full mode product
    a_r1_full_product: assert (split_en || prod_full == W'(W'(a_op) * W'(b_op)))
      else $error("full product mismatch");
    // R4: split results fit their N+N/2 field
    a_r4_lo_fits: assert (!split_en || fa0_sum[W-1:HW] == '0)
      else $error("low split result overflows");
    a_r5_hi_fits: assert (!split_en || fa1_sum[W-1:HW] == '0)
      else $error("high split result overflows");
    // R6: ports of the unused mode are zero
    a_r6_gate: assert (split_en ? (prod_full == '0) : (prod_lo == '0 && prod_hi == '0))
      else $error("inactive port not zero");
    // R8: split halves recombine into the full product
    a_r8_recombine: assert (!split_en ||
        (W'(prod_lo) + (W'(prod_hi) << H)) == W'(W'(a_op) * W'(b_op)))
      else $error("split halves do not recombine");
  end
endmodule

// File: tb/test_mt_mul_split.sv
`timescale 1ns/1ps
module test_mt_mul_split;
  localparam int N  = 16;
  localparam int H  = N / 2;
  localparam int PW = 2 * N;
  localparam int HW = N + H;
  localparam int NV = 8;

  localparam logic [N-1:0]  TA [NV] = '{16'h0003, 16'h00FF, 16'hFFFF, 16'h1234,
                                       16'h8000, 16'h0100, 16'hABCD, 16'h0002};
  localparam logic [N-1:0]  TB [NV] = '{16'h0005, 16'h0101, 16'hFFFF, 16'h0010,
                                       16'h8000, 16'h0100, 16'h0001, 16'h7FFF};
  localparam logic [PW-1:0] TP [NV] = '{32'h0000000F, 32'h0000FFFF, 32'hFFFE0001,
                                       32'h00012340, 32'h40000000, 32'h00010000,
                                       32'h0000ABCD, 32'h0000FFFE};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]  a_op = '0;
  logic [N-1:0]  b_op = '0;
  logic          split_en = 1'b0;
  logic [PW-1:0] prod_full;
  logic [HW-1:0] prod_lo, prod_hi;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  mt_mul_split #(.N(N)) i_mt_mul_split (
    .a_op(a_op), .b_op(b_op), .split_en(split_en),
    .prod_full(prod_full), .prod_lo(prod_lo), .prod_hi(prod_hi)
  );

  // shift-and-add reference over nb multiplier bits
  function automatic logic [63:0] ref_mul(input logic [63:0] x, input logic [63:0] y,
                                          input int nb);
    logic [63:0] acc;
    acc = '0;
    for (int i = 0; i < nb; i++)
      if (y[i]) acc = acc + (x << i);
    return acc;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (a=%h b=%h split=%b)",
               req, act, exp, a_op, b_op, split_en);
    end
  endtask

  task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b, input logic m);
    @(posedge clk);
    #1;
    a_op = a;
    b_op = b;
    split_en = m;
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [63:0] full_e;
    full_e = ref_mul(64'(a), 64'(b), N);
    apply(a, b, 1'b0);
    check("R1 full", 64'(prod_full), full_e);
    check("R6 lo off", 64'(prod_lo), 64'd0);
    check("R6 hi off", 64'(prod_hi), 64'd0);
    apply(a, b, 1'b1);
    check("R4 low half", 64'(prod_lo), ref_mul(64'(a), 64'(b[H-1:0]), H));
    check("R5 high half", 64'(prod_hi), ref_mul(64'(a), 64'(b[N-1:H]), H));
    check("R6 full off", 64'(prod_full), 64'd0);
    check("R8 recombine", 64'(prod_lo) + (64'(prod_hi) << H), full_e);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // idle state: zero operands, full mode
    @(negedge clk);
    check("R6 idle full", 64'(prod_full), 64'd0);
    check("R6 idle lo", 64'(prod_lo), 64'd0);

    // vector table: R1 against literal products (R2/R3 through the tree)
    for (int i = 0; i < NV; i++) begin
      apply(TA[i], TB[i], 1'b0);
      check("R1 table", 64'(prod_full), 64'(TP[i]));
      run_vec(TA[i], TB[i]);
    end

    // R7 corners
    apply('0, 16'hFFFF, 1'b0);
    check("R7 zero", 64'(prod_full), 64'd0);
    apply(16'h0001, 16'hBEEF, 1'b0);
    check("R7 one", 64'(prod_full), 64'h0000BEEF);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    check("R7 ones lo", 64'(prod_lo), 64'h00FEFF01);
    check("R7 ones hi", 64'(prod_hi), 64'h00FEFF01);
    apply(16'hFFFF, 16'h0000, 1'b1);
    check("R7 zero split", 64'(prod_lo) | 64'(prod_hi), 64'd0);
    // only one multiplier half non-zero
    run_vec(16'hFFFF, 16'hFF00);
    run_vec(16'hFFFF, 16'h00FF);
    run_vec(16'h0001, 16'h0100);

    // R9: mode flip without a clock edge changes outputs at once
    a_op = 16'h1357;
    b_op = 16'h2468;
    split_en = 1'b0;
    #0.5;
    check("R9 full now", 64'(prod_full), ref_mul(64'h1357, 64'h2468, N));
    split_en = 1'b1;
    #0.5;
    check("R9 split now", 64'(prod_hi), ref_mul(64'h1357, 64'h24, H));

    for (int i = 0; i < 300; i++)
      run_vec(N'($urandom), N'($urandom));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule